// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block holds the outcome of each finished transmit frame until the host has looked at it. When the transmit engine finishes a frame it presents a record of outcome flags for one cycle. The block stores up to a fixed number of such records, oldest first. The host sees the oldest record on an 8-bit status port and discards it by writing that port. A record that arrives while storage is full is dropped. The record the host will read next then carries an overflow flag, so software knows that outcomes were lost.

The block also sends a single-cycle completion event towards the interrupt logic whenever a frame ends with an error or with an explicit request for notification. It keeps two sticky conditions that stop the transmitter. The first is a need-reset state, entered on a jabber or underrun outcome. The second is an adapter-failure state, entered on a transmit-overrun indication. Both stay set until a transmit reset or a global reset. A transmit reset also empties the stored records.

Top module: `txs_stack_top`

## Requirements
- R1: A stored record reads on `statusByte` with these bits: 7 set (complete), 6 notify requested, 5 jabber, 4 underrun, 3 maximum collisions, 2 overflow. Bits 1:0 are always zero.
- R2: Records are presented oldest first, so the status port always shows the earliest record not yet popped.
- R3: A cycle with `hostWr` high removes the presented record. With no record stored, `statusByte` reads 0x00 and `hostWr` has no effect.
- R4: At most DEPTH (default 4) records are held. A push while full is dropped and sets bit 2 of the presented record.
- R5: `txCompleteEvt` is high for exactly the cycle after a push whose notify, jabber, underrun or max-collision flag is set. A push with all four clear gives no event.
- R6: A push with jabber or underrun sets `needReset` and drives `txEnable` low. Only a transmit reset or a global reset clears it.
- R7: `txOverrun` sets `adapterFail` and drives `txEnable` low until a transmit reset or a global reset.
- R8: `txReset` empties the storage and clears overflow, `needReset` and `adapterFail`. It takes priority over any push, pop or overrun in the same cycle, and it suppresses the event.
- R9: A push and a pop in the same cycle while full are both performed, and no overflow is marked.
- R10: After global reset the storage is empty, `statusByte` is 0x00, no event is raised, both sticky states are clear and `txEnable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Global reset, active low, synchronous |
| pushValid | input | 1 | A frame finished; push its record |
| pushIntReq | input | 1 | Frame asked for notification on success |
| pushJabber | input | 1 | Frame ended in a jabber error |
| pushUnderrun | input | 1 | Frame ended in a data underrun |
| pushMaxColl | input | 1 | Frame hit the collision retry limit |
| hostWr | input | 1 | Host write to the status port (pop) |
| txReset | input | 1 | Transmit reset command |
| txOverrun | input | 1 | Transmit FIFO overrun indication |
| statusByte | output | 8 | Oldest record, or 0x00 when empty |
| txCompleteEvt | output | 1 | One-cycle completion event |
| needReset | output | 1 | Sticky: jabber or underrun seen |
| adapterFail | output | 1 | Sticky: transmit overrun seen |
| txEnable | output | 1 | Transmitter may run |

## Verification
Records are pushed with different flag mixes and then drained. Reading them back in push order separates oldest-first presentation from newest-first, and it shows whether each flag lands on its own bit. Filling the storage and pushing past it tells a drop-and-mark policy apart from overwriting. Pushing and popping together at the full boundary tells whether the pop is counted before the push. A long randomized stretch then mixes pushes, pops, overruns and transmit resets at the same time, so that every priority between them is tried. A behavioural queue model checks all outputs on every clock.

// File: rtl/txs_pkg.sv
package txs_pkg;
  // Outcome flags of one stored frame, ordered to match status bits 6..2
  typedef struct packed {
    logic intReq;
    logic jabber;
    logic underrun;
    logic maxColl;
    logic ovf;
  } txRec_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic doPush;
    logic doPop;
    logic markOvf;
    logic flush;
  } txsStrb_t;
endpackage

// File: rtl/txs_ctrl.sv
module txs_ctrl
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pushValid,
  input  logic     pushIntReq,
  input  logic     pushJabber,
  input  logic     pushUnderrun,
  input  logic     pushMaxColl,
  input  logic     hostWr,
  input  logic     txReset,
  input  logic     txOverrun,
  output txsStrb_t strb,
  output logic     notEmpty,
  output logic     needReset,
  output logic     adapterFail,
  output logic     txCompleteEvt
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic popEff, pushAcc, wantEvt;

  assign notEmpty = (count != '0);
  assign popEff   = hostWr && notEmpty;
  // a pop in the same cycle frees a slot for the push
  assign pushAcc  = pushValid && ((count != FULL_CNT) || popEff);
  assign wantEvt  = pushValid && (pushIntReq || pushJabber || pushUnderrun || pushMaxColl);

  always_comb begin
    strb.flush   = txReset;
    strb.doPop   = popEff && !txReset;
    strb.doPush  = pushAcc && !txReset;
    strb.markOvf = pushValid && !pushAcc && !txReset;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count         <= '0;
      needReset     <= 1'b0;
      adapterFail   <= 1'b0;
      txCompleteEvt <= 1'b0;
    end else if (txReset) begin
      count         <= '0;
      needReset     <= 1'b0;
      adapterFail   <= 1'b0;
      txCompleteEvt <= 1'b0;
    end else begin
      count <= count + CNT_W'(pushAcc) - CNT_W'(popEff);
      if (pushValid && (pushJabber || pushUnderrun)) needReset <= 1'b1;
      if (txOverrun) adapterFail <= 1'b1;
      txCompleteEvt <= wantEvt;
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReset |=> (count == '0) && !needReset && !adapterFail && !txCompleteEvt);

  // R6
  need_reset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    needReset && !txReset |=> needReset);

  // R7
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    adapterFail && !txReset |=> adapterFail);

  // R5
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    txCompleteEvt |-> $past(pushValid) && !$past(txReset));
endmodule

// File: rtl/txs_datapath.sv
module txs_datapath
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  txsStrb_t   strb,
  input  txRec_t     pushRec,
  input  logic       notEmpty,
  output logic [7:0] statusOut
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  txRec_t mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
    end else begin
      if (strb.doPop)  rdPtr <= nextPtr(rdPtr);
      if (strb.doPush) wrPtr <= nextPtr(wrPtr);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[e] <= '0;
      end else if (!strb.flush) begin
        if (strb.doPush && wrPtr == PTR_W'(e)) mem[e] <= pushRec;
        else if (strb.markOvf && rdPtr == PTR_W'(e)) mem[e].ovf <= 1'b1;
      end
    end
  end

  assign statusOut = notEmpty ? {1'b1, mem[rdPtr], 2'b00} : 8'h00;

  // R3
  pop_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPop && !strb.flush |=> rdPtr == nextPtr($past(rdPtr)));
endmodule

// File: rtl/txs_stack_top.sv
module txs_stack_top
  import txs_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushValid,
  input  logic       pushIntReq,
  input  logic       pushJabber,
  input  logic       pushUnderrun,
  input  logic       pushMaxColl,
  input  logic       hostWr,
  input  logic       txReset,
  input  logic       txOverrun,
  output logic [7:0] statusByte,
  output logic       txCompleteEvt,
  output logic       needReset,
  output logic       adapterFail,
  output logic       txEnable
);
  txsStrb_t strb;
  txRec_t   pushRec;
  logic     notEmpty;

  assign pushRec = '{intReq: pushIntReq, jabber: pushJabber, underrun: pushUnderrun,
                     maxColl: pushMaxColl, ovf: 1'b0};

  txs_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushIntReq(pushIntReq),
    .pushJabber(pushJabber), .pushUnderrun(pushUnderrun), .pushMaxColl(pushMaxColl),
    .hostWr(hostWr), .txReset(txReset), .txOverrun(txOverrun), .strb(strb),
    .notEmpty(notEmpty), .needReset(needReset), .adapterFail(adapterFail),
    .txCompleteEvt(txCompleteEvt)
  );

  txs_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .pushRec(pushRec),
    .notEmpty(notEmpty), .statusOut(statusByte)
  );

  assign txEnable = !(needReset || adapterFail);

  // R1
  low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[1:0] == 2'b00 && (statusByte == 8'h00 || statusByte[7]));
endmodule

// File: tb/txs_stack_top_tb_top.sv
module txs_stack_top_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 0, pushIntReq = 0, pushJabber = 0, pushUnderrun = 0, pushMaxColl = 0;
  logic hostWr = 0, txReset = 0, txOverrun = 0;
  logic [7:0] statusByte;
  logic txCompleteEvt, needReset, adapterFail, txEnable;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] q[$];
  bit mNeed = 0, mFail = 0, mEvt = 0;

  always #4 clk = ~clk;

  txs_stack_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushIntReq(pushIntReq),
    .pushJabber(pushJabber), .pushUnderrun(pushUnderrun), .pushMaxColl(pushMaxColl),
    .hostWr(hostWr), .txReset(txReset), .txOverrun(txOverrun),
    .statusByte(statusByte), .txCompleteEvt(txCompleteEvt), .needReset(needReset),
    .adapterFail(adapterFail), .txEnable(txEnable)
  );

  // behavioural reference
  always @(posedge clk) begin
    if (!rstN || txReset) begin
      q.delete();
      mNeed = 0; mFail = 0; mEvt = 0;
    end else begin
      mEvt = pushValid && (pushIntReq || pushJabber || pushUnderrun || pushMaxColl);
      if (hostWr && q.size() > 0) void'(q.pop_front());
      if (pushValid) begin
        if (q.size() < DEPTH)
          q.push_back({1'b1, pushIntReq, pushJabber, pushUnderrun, pushMaxColl, 3'b000});
        else
          q[0] = q[0] | 8'h04;
        if (pushJabber || pushUnderrun) mNeed = 1;
      end
      if (txOverrun) mFail = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R1 R2 R3 statusByte", statusByte, (q.size() > 0) ? q[0] : 8'h00);
      chk("R5 txCompleteEvt", txCompleteEvt, mEvt);
      chk("R6 needReset", needReset, mNeed);
      chk("R7 adapterFail", adapterFail, mFail);
      chk("R6 R7 txEnable", txEnable, !(mNeed || mFail));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input bit pv, input bit ir, input bit jb, input bit un,
                      input bit mc, input bit hw, input bit tr, input bit ov);
    @(posedge clk);
    #2;
    pushValid = pv; pushIntReq = ir; pushJabber = jb; pushUnderrun = un;
    pushMaxColl = mc; hostWr = hw; txReset = tr; txOverrun = ov;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0,0,0,0,0,0,0,0);
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    idle(1);
    @(negedge clk);
    chk("R10 reset status", statusByte, 8'h00);
    chk("R10 reset enable", txEnable, 1);

    // R1 R2: distinct flag mixes read back in push order
    step(1,0,0,0,0,0,0,0);   // clean success, 0x80
    step(1,1,0,0,0,0,0,0);   // notify, 0xC0
    step(1,0,0,0,1,0,0,0);   // max collisions, 0x88
    idle(1);
    @(negedge clk);
    chk("R2 oldest first", statusByte, 8'h80);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,1,0,0);
    step(0,0,0,0,0,1,0,0);
    // R3: pop while empty leaves status at zero
    step(0,0,0,0,0,1,0,0);
    idle(1);
    @(negedge clk);
    chk("R3 empty read", statusByte, 8'h00);

    // R4: fill, then overflow with a jabber record (R6)
    for (int i = 0; i < DEPTH; i++) step(1,0,0,0,i[0],0,0,0);
    step(1,0,1,0,0,0,0,0);
    idle(1);
    @(negedge clk);
    chk("R4 overflow marked", statusByte, 8'h84);
    chk("R6 latched", needReset, 1);

    // R9: push with pop at full
    step(1,1,0,0,0,1,0,0);
    idle(2);

    // R8: reset with simultaneous push, pop and overrun
    step(1,1,0,1,0,1,1,1);
    idle(1);
    @(negedge clk);
    chk("R8 flushed", statusByte, 8'h00);
    chk("R8 cleared", txEnable, 1);

    // R7: overrun, then pushes still recorded, then clear
    step(0,0,0,0,0,0,0,1);
    step(1,0,0,1,0,0,0,0);
    idle(3);
    step(0,0,0,0,0,0,1,0);
    idle(1);

    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step(r[0] | r[1], r[2] & r[3], r[4] & r[5] & r[6], r[7] & r[8] & r[9],
           r[10] & r[11], r[12] & r[13], (r[23:16] == 8'h00), (r[31:25] == 7'h00));
      if (r[31:20] == 12'h000) begin
        rstN = 1'b0;
        step(0,0,0,0,0,0,0,0);
        rstN = 1'b1;
      end
    end
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule